// File: doc/BRIEF.md
# Paged Digital I/O Port Controller with Edge Capture

This block drives and senses 48 open-drain lines grouped as six 8-bit ports. A byte written to a port sets which of its lines are pulled low: a 1 sinks the pin, and a 0 releases it to an external pull-up. Reading a port returns the synchronised pin levels inverted, so a released, high pin reads 0. This lets the same port serve as an output and as an input.

The lines of the first three ports can record edges. Each line has a polarity bit that picks a rising or a falling edge, and an enable bit. A qualifying edge on an enabled line sets a sticky identifier bit. Software clears that bit by writing 0 to it. The polarity, enable and identifier registers share one three-byte window. Two bits in a page/lock register choose which bank appears in that window, and the low six bits of the same register write-protect individual ports. A pending register summarises which ports hold captured edges. The interrupt line stays high while any identifier bit is set.

A synchronous bus with separate write and read strobes reaches every register. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `pdio_ctrl`

## Requirements
- R1: After reset, every port, polarity, enable and identifier register is zero, page/lock reads 0x00, no line is driven low and `irq` is low.
- R2: A write to address 0x10+p (p = 0..5) of an unlocked port loads that port, and `pin_drive_low[8p+7:8p]` equals the written byte after that clock edge. No other input changes the driven lines.
- R3: A read of address 0x10+p returns the bitwise inverse of the port's pins, sampled through a two-stage synchroniser.
- R4: Address 0x17 holds the page in bits 7:6 and one lock bit per port in bits 5:0 (bit p locks port p). It reads back as written, and a lock bit affects only its own port.
- R5: A write to a locked port leaves its driven lines unchanged, and a read of that port still returns the inverted pins.
- R6: At addresses 0x18..0x1A (ports 0..2), page 1 maps polarity, page 2 maps enable and page 3 maps the identifier registers. On page 0 these addresses read 0 and writes to them are ignored.
- R7: For lines 0..23, an enabled line whose polarity bit is 1 latches a rising pin edge, and one whose polarity bit is 0 latches a falling edge. The identifier bit becomes visible on the third rising clock edge after the pin changes.
- R8: An edge on a line whose enable bit is 0, or an edge of the opposite direction, sets no identifier bit.
- R9: Writing to an identifier register clears each bit written as 0 and keeps each bit written as 1. An edge captured in the same cycle still sets its bit.
- R10: Address 0x16 reads bit p (p = 0..2) as 1 when port p has any identifier bit set. Bits 7:3 read 0.
- R11: `irq` is high exactly while at least one identifier bit is set, and it stays high until every set bit has been cleared.
- R12: Lines 24..47 never cause an identifier bit to set or `irq` to rise.
- R13: Addresses 0x00..0x0F and 0x1B..0x1F read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; `bus_rdata` updates on that edge |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin levels, asynchronous to `clk` |
| pin_drive_low | output | 48 | 1 = sink the pin low, 0 = release it |
| irq | output | 1 | Level interrupt: OR of all identifier bits |

## Verification
The bench builds the block with its defaults: six ports, three of them able to capture edges, and a two-stage synchroniser. With those defaults the address map is completely filled, so the 0x16 pending register sits directly after the last port. The six-bit lock field then covers every port, and the three-cycle capture delay can be checked cycle by cycle. A behavioural model driven by the same strobes and pin stimulus checks that the paged window, the lock bits and the same-cycle clear/capture case stay consistent across a long pseudo-random run.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 5;
  localparam int LOCK_W = 6;

  // Fixed decode points of the register window.
  localparam logic [ADDR_W-1:0] OFS_PORT0    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_PENDING  = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_PAGELOCK = 5'h17;
  localparam logic [ADDR_W-1:0] OFS_PAGED0   = 5'h18;

  typedef enum logic [1:0] {
    PG_PORTS = 2'd0,
    PG_POL   = 2'd1,
    PG_EN    = 2'd2,
    PG_ID    = 2'd3
  } page_e;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] din;
    logic [WIDTH-1:0] r_q;
    if (s == 0) begin : g_first
      assign din = d;
    end else begin : g_next
      assign din = g_stage[s-1].r_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= din;
    end
  end

  assign q = g_stage[STAGES-1].r_q;
endmodule

// File: rtl/pdio_port_bank.sv
module pdio_port_bank
  import pdio_pkg::*;
#(
  parameter int N_PORTS = 6,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [PORT_W-1:0]         wdata,
  input  logic [N_PORTS-1:0]        lock,
  output logic [N_PORTS*PORT_W-1:0] drive_low
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic              ld;
    logic [PORT_W-1:0] port_d;
    logic [PORT_W-1:0] port_q;

    // Load enable: addressed and not write-protected.
    assign ld = wr_en && (wr_idx == IDX_W'(g)) && !lock[g];

    always_comb begin
      port_d = port_q;
      if (ld) port_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_q <= '0;
      else        port_q <= port_d;
    end

    assign drive_low[g*PORT_W +: PORT_W] = port_q;
  end
endmodule

// File: rtl/pdio_edge_bank.sv
module pdio_edge_bank
  import pdio_pkg::*;
#(
  parameter int N_IRQ_PORTS = 3,
  parameter int IDX_W       = 3,
  localparam int LINES      = N_IRQ_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_s,
  input  logic              wr_en,
  input  page_e             wr_page,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wdata,
  output logic [LINES-1:0]  pol_all,
  output logic [LINES-1:0]  en_all,
  output logic [LINES-1:0]  id_all
);
  // Previous synchronised level, for edge detection.
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_s;
  end

  for (genvar g = 0; g < N_IRQ_PORTS; g++) begin : g_port
    logic [PORT_W-1:0] cur, old, ev;
    logic [PORT_W-1:0] pol_d, pol_q, en_d, en_q, id_d, id_q;
    logic              sel;

    assign cur = line_s[g*PORT_W +: PORT_W];
    assign old = prev_q[g*PORT_W +: PORT_W];
    // Qualified edge: direction by polarity, masked by enable.
    assign ev  = en_q & ((pol_q & cur & ~old) | (~pol_q & ~cur & old));
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      pol_d = pol_q;
      en_d  = en_q;
      id_d  = id_q;
      if (sel && (wr_page == PG_POL)) pol_d = wdata;
      if (sel && (wr_page == PG_EN))  en_d  = wdata;
      if (sel && (wr_page == PG_ID))  id_d  = id_q & wdata;
      id_d = id_d | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q <= '0;
        en_q  <= '0;
        id_q  <= '0;
      end else begin
        pol_q <= pol_d;
        en_q  <= en_d;
        id_q  <= id_d;
      end
    end

    assign pol_all[g*PORT_W +: PORT_W] = pol_q;
    assign en_all[g*PORT_W +: PORT_W]  = en_q;
    assign id_all[g*PORT_W +: PORT_W]  = id_q;
  end
endmodule

// File: rtl/pdio_ctrl.sv
module pdio_ctrl
  import pdio_pkg::*;
#(
  parameter int N_PORTS     = 6,   // at most LOCK_W
  parameter int N_IRQ_PORTS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [4:0]                bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  input  logic [N_PORTS*8-1:0]      pin_in,
  output logic [N_PORTS*8-1:0]      pin_drive_low,
  output logic                      irq
);
  localparam int LINES     = N_PORTS * PORT_W;
  localparam int IRQ_LINES = N_IRQ_PORTS * PORT_W;
  localparam int IDX_W     = $clog2(N_PORTS);

  logic [LINES-1:0]       pin_s;
  logic [IRQ_LINES-1:0]   pol_all, en_all, id_all;
  logic [N_IRQ_PORTS-1:0] pend;
  logic [ADDR_W-1:0]      port_ofs, pg_ofs;
  logic [IDX_W-1:0]       port_idx, pg_idx;
  logic                   port_sel, paged_sel, pl_ld;
  page_e                  page_d, page_q;
  logic [LOCK_W-1:0]      lock_d, lock_q;
  logic [PORT_W-1:0]      rd_val, rdata_d, rdata_q;

  // Address decode
  assign port_ofs  = bus_addr - OFS_PORT0;
  assign pg_ofs    = bus_addr - OFS_PAGED0;
  assign port_sel  = (bus_addr >= OFS_PORT0) && (port_ofs < ADDR_W'(N_PORTS));
  assign paged_sel = (bus_addr >= OFS_PAGED0) && (pg_ofs < ADDR_W'(N_IRQ_PORTS));
  assign port_idx  = port_ofs[IDX_W-1:0];
  assign pg_idx    = pg_ofs[IDX_W-1:0];
  assign pl_ld     = bus_wr && (bus_addr == OFS_PAGELOCK);

  pdio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  pdio_port_bank #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_ports (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && port_sel), .wr_idx(port_idx), .wdata(bus_wdata),
    .lock(lock_q[N_PORTS-1:0]), .drive_low(pin_drive_low)
  );

  pdio_edge_bank #(.N_IRQ_PORTS(N_IRQ_PORTS), .IDX_W(IDX_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .line_s(pin_s[IRQ_LINES-1:0]),
    .wr_en(bus_wr && paged_sel && (page_q != PG_PORTS)),
    .wr_page(page_q), .wr_idx(pg_idx), .wdata(bus_wdata),
    .pol_all(pol_all), .en_all(en_all), .id_all(id_all)
  );

  for (genvar g = 0; g < N_IRQ_PORTS; g++) begin : g_pend
    assign pend[g] = |id_all[g*PORT_W +: PORT_W];
  end
  assign irq = |id_all;

  // Page/lock register
  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (pl_ld) begin
      page_d = page_e'(bus_wdata[7:6]);
      lock_d = bus_wdata[LOCK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PG_PORTS;
      lock_q <= '0;
    end else begin
      page_q <= page_d;
      lock_q <= lock_d;
    end
  end

  // Read mux and registered read data
  always_comb begin
    rd_val = '0;
    if (port_sel) begin
      rd_val = ~pin_s[port_idx*PORT_W +: PORT_W];
    end else if (bus_addr == OFS_PENDING) begin
      rd_val = PORT_W'(pend);
    end else if (bus_addr == OFS_PAGELOCK) begin
      rd_val = {page_q, lock_q};
    end else if (paged_sel) begin
      case (page_q)
        PG_POL:  rd_val = pol_all[pg_idx*PORT_W +: PORT_W];
        PG_EN:   rd_val = en_all[pg_idx*PORT_W +: PORT_W];
        PG_ID:   rd_val = id_all[pg_idx*PORT_W +: PORT_W];
        default: rd_val = '0;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pdio_ctrl_chk.sv
module pdio_ctrl_chk #(
  parameter int N_PORTS     = 6,
  parameter int N_IRQ_PORTS = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [4:0]               bus_addr,
  input logic [7:0]               bus_wdata,
  input logic [7:0]               bus_rdata,
  input logic [N_PORTS*8-1:0]     pin_drive_low,
  input logic                     irq,
  input logic [5:0]               lock_q,
  input logic [1:0]               page_q,
  input logic [N_IRQ_PORTS*8-1:0] en_all
);
  logic id_wr, paged_addr;
  assign paged_addr = (bus_addr >= 5'h18) && (bus_addr <= 5'(5'h17 + N_IRQ_PORTS));
  assign id_wr      = bus_wr && paged_addr && (page_q == 2'd3);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'(5'h10 + g) && !lock_q[g])
        |=> (pin_drive_low[g*8 +: 8] == $past(bus_wdata)));
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'(5'h10 + g) && lock_q[g])
        |=> $stable(pin_drive_low[g*8 +: 8]));
  end

  p_drive_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_drive_low));

  p_irq_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !id_wr) |=> irq);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && en_all == '0) |=> !irq);

  p_pending_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 5'h16)
      |=> (bus_rdata[7:3] == 5'd0) && ((bus_rdata[2:0] != 3'd0) == $past(irq)));

  p_page0_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && paged_addr && page_q == 2'd0) |=> (bus_rdata == 8'h00));

  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr < 5'h10 || bus_addr > 5'h1A)) |=> (bus_rdata == 8'h00));
endmodule

bind pdio_ctrl pdio_ctrl_chk #(.N_PORTS(N_PORTS), .N_IRQ_PORTS(N_IRQ_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_drive_low(pin_drive_low), .irq(irq), .lock_q(lock_q),
  .page_q(page_q), .en_all(en_all)
);

// File: tb/pdio_ctrl_test.sv
`timescale 1ns/1ps
module pdio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in, pin_drive_low, ext_pull;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // Open-drain wiring: a pin is low when the block or the outside pulls it.
  assign pin_in = ~(pin_drive_low | ext_pull);

  pdio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_drive_low(pin_drive_low), .irq(irq)
  );

  task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_port [6];
  logic [7:0]  m_pol [3];
  logic [7:0]  m_en [3];
  logic [7:0]  m_id [3];
  logic [1:0]  m_page;
  logic [5:0]  m_lock;
  logic [47:0] hist [$];
  logic [7:0]  m_rdata;
  logic [7:0]  m_ev [3];
  bit          m_rd_valid = 1'b0;
  bit          m_ready = 1'b0;

  function automatic logic [7:0] mread(input logic [4:0] a);
    logic [47:0] seen;
    seen = hist[1];
    if (a >= 5'h10 && a <= 5'h15) return ~seen[(a - 5'h10) * 8 +: 8];
    if (a == 5'h16) return {5'd0, |m_id[2], |m_id[1], |m_id[0]};
    if (a == 5'h17) return {m_page, m_lock};
    if (a >= 5'h18 && a <= 5'h1A) begin
      case (m_page)
        2'd1: return m_pol[a - 5'h18];
        2'd2: return m_en[a - 5'h18];
        2'd3: return m_id[a - 5'h18];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 6; p++) m_port[p] = 8'h00;
      for (int p = 0; p < 3; p++) begin m_pol[p] = 0; m_en[p] = 0; m_id[p] = 0; end
      m_page = 0; m_lock = 0; m_rd_valid = 0; m_ready = 1;
      hist = '{48'h0, 48'h0, 48'h0};
    end else begin
      m_rd_valid = bus_rd;
      if (bus_rd) m_rdata = mread(bus_addr);
      for (int p = 0; p < 3; p++) begin
        for (int b = 0; b < 8; b++) begin
          logic c, o;
          c = hist[1][p*8+b];
          o = hist[2][p*8+b];
          m_ev[p][b] = m_en[p][b] && (m_pol[p][b] ? (c && !o) : (!c && o));
        end
      end
      if (bus_wr) begin
        if (bus_addr >= 5'h10 && bus_addr <= 5'h15) begin
          if (!m_lock[bus_addr - 5'h10]) m_port[bus_addr - 5'h10] = bus_wdata;
        end else if (bus_addr == 5'h17) begin
          m_page = bus_wdata[7:6];
          m_lock = bus_wdata[5:0];
        end else if (bus_addr >= 5'h18 && bus_addr <= 5'h1A) begin
          case (m_page)
            2'd1: m_pol[bus_addr - 5'h18] = bus_wdata;
            2'd2: m_en[bus_addr - 5'h18] = bus_wdata;
            2'd3: m_id[bus_addr - 5'h18] = m_id[bus_addr - 5'h18] & bus_wdata;
            default: ;
          endcase
        end
      end
      for (int p = 0; p < 3; p++) m_id[p] = m_id[p] | m_ev[p];
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && m_ready && !finished) begin
      logic [47:0] exp_drive;
      for (int p = 0; p < 6; p++) exp_drive[p*8 +: 8] = m_port[p];
      chk(pin_drive_low, exp_drive, "R2 drive vs model");
      chk({47'd0, irq}, {47'd0, (|m_id[0]) | (|m_id[1]) | (|m_id[2])}, "R11 irq vs model");
      if (m_rd_valid) chk({40'd0, bus_rdata}, {40'd0, m_rdata}, "R3 read vs model");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<60000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0]  rv;
    logic [47:0] snap;
    logic [31:0] lf;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; ext_pull = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    chk(pin_drive_low, 48'h0, "R1 drive after reset");
    chk({47'd0, irq}, 48'h0, "R1 irq after reset");
    do_read(5'h17, rv); chk({40'd0, rv}, 48'h00, "R1 page/lock after reset");
    wait_cyc(4);
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h00, "R1 paged after reset");

    // Port output and inverted readback
    do_write(5'h11, 8'hA5);
    chk({40'd0, pin_drive_low[15:8]}, 48'hA5, "R2 port1 drive");
    wait_cyc(3);
    do_read(5'h11, rv); chk({40'd0, rv}, 48'hA5, "R3 port1 driven pins read back");
    do_read(5'h10, rv); chk({40'd0, rv}, 48'h00, "R3 released pins read 0");
    ext_pull[39:32] = 8'h3C;
    wait_cyc(3);
    do_read(5'h14, rv); chk({40'd0, rv}, 48'h3C, "R3 external lows on port4");

    // Page/lock
    do_write(5'h17, 8'h42);
    do_read(5'h17, rv); chk({40'd0, rv}, 48'h42, "R4 page/lock readback");
    do_write(5'h11, 8'h00);
    chk({40'd0, pin_drive_low[15:8]}, 48'hA5, "R5 locked port keeps drive");
    ext_pull[15:8] = 8'h0F;
    wait_cyc(3);
    do_read(5'h11, rv); chk({40'd0, rv}, 48'hAF, "R5 locked port still reads pins");
    do_write(5'h15, 8'h81);
    chk({40'd0, pin_drive_low[47:40]}, 48'h81, "R4 lock bit only hits its port");

    // Paged window
    do_write(5'h18, 8'h01);
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h01, "R6 polarity page");
    do_write(5'h17, 8'h82);
    do_write(5'h18, 8'h07);
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h07, "R6 enable page");
    do_write(5'h17, 8'h02);
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h00, "R6 page 0 reads zero");
    do_write(5'h19, 8'hFF);
    do_write(5'h17, 8'h82);
    do_read(5'h19, rv); chk({40'd0, rv}, 48'h00, "R6 page 0 write ignored");

    // Edge capture
    ext_pull[0] = 1'b1;
    wait_cyc(4);
    chk({47'd0, irq}, 48'h0, "R8 opposite edge not latched");
    ext_pull[0] = 1'b0;
    wait_cyc(2);
    chk({47'd0, irq}, 48'h0, "R7 not visible before third edge");
    wait_cyc(1);
    chk({47'd0, irq}, 48'h1, "R7 rising edge latched");
    ext_pull[1] = 1'b1;
    ext_pull[3] = 1'b1;
    wait_cyc(4);
    do_write(5'h17, 8'hC2);
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h03, "R8 falling latched, disabled line not");
    do_read(5'h16, rv); chk({40'd0, rv}, 48'h01, "R10 pending port0");
    do_write(5'h18, 8'h02);
    chk({47'd0, irq}, 48'h1, "R11 irq held while a bit remains");
    do_read(5'h18, rv); chk({40'd0, rv}, 48'h02, "R9 zero clears, one keeps");
    do_write(5'h18, 8'h00);
    chk({47'd0, irq}, 48'h0, "R11 irq drops when all cleared");
    do_read(5'h16, rv); chk({40'd0, rv}, 48'h00, "R10 pending empty");

    // Upper lines cannot interrupt
    do_write(5'h17, 8'h82);
    do_write(5'h19, 8'hFF);
    do_write(5'h1A, 8'hFF);
    ext_pull[31:24] = 8'hFF;
    wait_cyc(4);
    chk({47'd0, irq}, 48'h0, "R12 port3 falling edges");
    ext_pull[31:24] = 8'h00;
    wait_cyc(4);
    chk({47'd0, irq}, 48'h0, "R12 port3 rising edges");

    // Unmapped addresses
    snap = pin_drive_low;
    do_write(5'h05, 8'hFF);
    do_write(5'h1F, 8'hFF);
    chk(pin_drive_low, snap, "R13 unmapped writes ignored");
    do_read(5'h1F, rv); chk({40'd0, rv}, 48'h00, "R13 read 0x1F");
    do_read(5'h03, rv); chk({40'd0, rv}, 48'h00, "R13 read 0x03");

    // Pseudo-random traffic, checked against the model each cycle
    lf = 32'h1234_5671;
    for (int n = 0; n < 600; n++) begin
      int li;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bus_wr    = lf[0];
      bus_rd    = lf[1];
      bus_addr  = lf[2] ? 5'(5'h10 + (lf[7:4] % 11)) : lf[12:8];
      bus_wdata = lf[20:13];
      li = int'(lf[29:24]) % 48;
      if (lf[3]) ext_pull[li] = ~ext_pull[li];
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0;
    wait_cyc(2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule